// File: doc/BRIEF.md
# Mask-based bidirectional barrel shifter

This block is a purely combinational shifter and rotator for a data word of `W` bits, where `W` is a power of two. One pass performs any of six operations: logical or arithmetic shift right, rotate right, logical or arithmetic shift left, and rotate left. The operation is chosen by three control bits: direction, rotate and arithmetic. The amount is an unsigned value of log2(`W`) bits.

Only one rotator is built, and it turns right. For a left operation the word is mirrored before the rotator and mirrored again after it. Shifts come from a fill mask that is built while the rotation runs. The rotator output is kept where the mask is set. Elsewhere the fill value is used, which is the sign bit for an arithmetic right shift and zero in every other case. The zero flag and the overflow flag are both taken from masks applied to the operand, not from the finished result. Both flags are therefore ready at about the same time as the data.

Top module: `bsh_shifter`

## Requirements
- R1: The control code {dir_left_i, rotate_i, arith_i} decodes as follows: 000 is logical right shift, 001 is arithmetic right shift, 010 and 011 are rotate right, 100 is logical left shift, 101 is arithmetic left shift, and 110 and 111 are rotate left. When rotate_i is 1, arith_i has no effect.
- R2: A logical right shift by B gives y_o[i] = a_i[i+B] for i+B < W, and 0 for the top B bits.
- R3: An arithmetic right shift by B gives y_o[i] = a_i[i+B] for i+B < W, and the top B bits all equal a_i[W-1].
- R4: A rotate right by B gives y_o[i] = a_i[(i+B) mod W]. A rotate left by B gives y_o[i] = a_i[(i-B) mod W].
- R5: A logical left shift by B gives y_o[i] = a_i[i-B] for i >= B, and 0 for the low B bits.
- R6: An arithmetic left shift by B gives the logical left shift result, except that y_o[W-1] equals a_i[W-1].
- R7: ovf_o is 1 only for an arithmetic left shift. It is 1 when any of a_i[W-1-B] to a_i[W-2] differs from a_i[W-1], and it is 0 for B = 0.
- R8: zero_o is 1 exactly when all W bits of y_o are 0, for every operation.
- R9: For B = 0, every operation returns y_o equal to a_i, with ovf_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand |
| amt_i | input | $clog2(W) | Unsigned shift or rotate amount |
| dir_left_i | input | 1 | 1 selects a left operation |
| rotate_i | input | 1 | 1 selects a rotation |
| arith_i | input | 1 | 1 selects an arithmetic shift |
| y_o | output | W | Result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Arithmetic left shift lost significant bits |

## Verification
The two flags can be raised by the same input. An arithmetic left shift whose discarded bits differ from the sign, and which leaves nothing but zeros, raises overflow and zero together. Examples are 0x40000000 shifted by 2 at 32 bits and 0x40 shifted by 2 at 8 bits. These cases are applied as directed inputs, and they also arise within a sweep over every amount and every control code with random operands. A scoreboard judges each flag on its own against a reference. The reference derives the zero flag from the expected result and the overflow flag from a scan of the operand bits, and it does not use masks.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [2:0] {
    OP_SRL = 3'd0,
    OP_SRA = 3'd1,
    OP_ROR = 3'd2,
    OP_SLL = 3'd3,
    OP_SLA = 3'd4,
    OP_ROL = 3'd5
  } bsh_op_e;

  // Map the three control bits to an operation; arith is ignored for rotations.
  function automatic bsh_op_e bsh_decode(input logic left, input logic rot, input logic arith);
    bsh_op_e op;
    if (rot)        op = left ? OP_ROL : OP_ROR;
    else if (left)  op = arith ? OP_SLA : OP_SLL;
    else            op = arith ? OP_SRA : OP_SRL;
    return op;
  endfunction

endpackage

// File: rtl/bsh_reverse.sv
module bsh_reverse #(
  parameter int W = 32
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] mirrored;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mirrored[i] = d_i[W-1-i];
  end

  assign q_o = en_i ? mirrored : d_i;
endmodule

// File: rtl/bsh_rotr.sv
module bsh_rotr #(
  parameter int W = 32
) (
  input  logic [W-1:0]         d_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         q_o
);
  localparam int LW = $clog2(W);

  logic [W-1:0] stage [LW+1];

  assign stage[0] = d_i;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
  end

  assign q_o = stage[LW];
endmodule

// File: rtl/bsh_masks.sv
module bsh_masks #(
  parameter int W = 32
) (
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 rotate_i,
  input  logic                 sla_i,
  input  logic [W-1:0]         a_i,
  output logic [W-1:0]         keep_o,
  output logic [W-1:0]         pass_o,
  output logic [W-1:0]         live_o,
  output logic                 ovf_o
);
  localparam int LW = $clog2(W);

  // Bit i of the keep mask is set while i + amt stays below W.
  function automatic logic keep_bit(input int idx, input logic [LW-1:0] amt);
    logic [LW:0] sum;
    sum = (LW+1)'(idx) + {1'b0, amt};
    return sum < (LW+1)'(W);
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep_o[i] = keep_bit(i, amt_i);
  end

  assign pass_o = keep_o | {W{rotate_i}};

  // Live mask: the mirrored-operand bits that reach the result.
  assign live_o[0] = pass_o[W-1] | sla_i;
  for (genvar i = 1; i < W; i++) begin : g_live
    assign live_o[i] = sla_i ? pass_o[W-i] : pass_o[W-1-i];
  end

  logic [W-2:0] differs;
  logic [W-2:0] lost;
  assign differs = a_i[W-2:0] ^ {(W-1){a_i[W-1]}};
  assign lost    = differs & ~keep_o[W-1:1];
  assign ovf_o   = sla_i & (|lost);
endmodule

// File: rtl/bsh_shifter.sv
module bsh_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 dir_left_i,
  input  logic                 rotate_i,
  input  logic                 arith_i,
  output logic [W-1:0]         y_o,
  output logic                 zero_o,
  output logic                 ovf_o
);
  import bsh_pkg::*;

  bsh_op_e      op_w;
  logic         sra_w;
  logic         sla_w;
  logic         fill_w;
  logic [W-1:0] a_mir;
  logic [W-1:0] rot_w;
  logic [W-1:0] keep_w;
  logic [W-1:0] pass_w;
  logic [W-1:0] live_w;
  logic [W-1:0] pre_w;

  assign op_w   = bsh_decode(dir_left_i, rotate_i, arith_i);
  assign sra_w  = (op_w == OP_SRA);
  assign sla_w  = (op_w == OP_SLA);
  assign fill_w = sra_w & a_i[W-1];

  bsh_reverse #(.W(W)) u_rev_in (
    .en_i (dir_left_i),
    .d_i  (a_i),
    .q_o  (a_mir)
  );

  bsh_rotr #(.W(W)) u_rot (
    .d_i   (a_mir),
    .amt_i (amt_i),
    .q_o   (rot_w)
  );

  bsh_masks #(.W(W)) u_masks (
    .amt_i    (amt_i),
    .rotate_i (rotate_i),
    .sla_i    (sla_w),
    .a_i      (a_i),
    .keep_o   (keep_w),
    .pass_o   (pass_w),
    .live_o   (live_w),
    .ovf_o    (ovf_o)
  );

  assign pre_w[0] = sla_w ? a_mir[0] : (pass_w[0] ? rot_w[0] : fill_w);
  for (genvar i = 1; i < W; i++) begin : g_sel
    assign pre_w[i] = pass_w[i] ? rot_w[i] : fill_w;
  end

  bsh_reverse #(.W(W)) u_rev_out (
    .en_i (dir_left_i),
    .d_i  (pre_w),
    .q_o  (y_o)
  );

  assign zero_o = ~|(a_mir & live_w);
endmodule

// File: rtl/bsh_shifter_chk.sv
module bsh_shifter_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]         a_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic                 dir_left_i,
  input logic                 rotate_i,
  input logic                 arith_i,
  input logic [W-1:0]         y_o,
  input logic                 zero_o,
  input logic                 ovf_o,
  input logic                 sla_w
);
  logic sla_ref;
  logic sra_ref;
  assign sla_ref = dir_left_i & ~rotate_i & arith_i;
  assign sra_ref = ~dir_left_i & ~rotate_i & arith_i;

  always_comb begin
    // R7
    a_r7_no_overflow: assert (sla_ref || !ovf_o);
    // R1
    a_r1_sla_decode: assert (sla_w == sla_ref);
    // R8
    a_r8_zero_flag: assert (zero_o == (y_o == '0));
    // R9
    a_r9_identity: assert (amt_i != '0 || (y_o == a_i && !ovf_o));
    // R6
    a_r6_sla_sign: assert (!sla_ref || y_o[W-1] == a_i[W-1]);
    // R4
    a_r4_rotate_bits: assert (!rotate_i || $countones(y_o) == $countones(a_i));
    // R3
    a_r3_sra_top: assert (!(sra_ref && a_i[W-1]) || y_o[W-1]);
  end
endmodule

bind bsh_shifter bsh_shifter_chk #(.W(W)) u_chk (
  .a_i        (a_i),
  .amt_i      (amt_i),
  .dir_left_i (dir_left_i),
  .rotate_i   (rotate_i),
  .arith_i    (arith_i),
  .y_o        (y_o),
  .zero_o     (zero_o),
  .ovf_o      (ovf_o),
  .sla_w      (sla_w)
);

// File: tb/bsh_shifter_test.sv
module bsh_shifter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] a32 = '0;
  logic [4:0]  b32 = '0;
  logic [7:0]  a8  = '0;
  logic [2:0]  b8  = '0;
  logic l = 1'b0, r = 1'b0, ar = 1'b0;
  logic [31:0] y32; logic z32, o32;
  logic [7:0]  y8;  logic z8,  o8;

  bsh_shifter #(.W(32)) uut (
    .a_i(a32), .amt_i(b32), .dir_left_i(l), .rotate_i(r), .arith_i(ar),
    .y_o(y32), .zero_o(z32), .ovf_o(o32));

  bsh_shifter #(.W(8)) uut8 (
    .a_i(a8), .amt_i(b8), .dir_left_i(l), .rotate_i(r), .arith_i(ar),
    .y_o(y8), .zero_o(z8), .ovf_o(o8));

  typedef struct {
    logic [31:0] y32; logic z32; logic o32;
    logic [31:0] y8;  logic z8;  logic o8;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference: bit-by-bit from the requirement text.
  function automatic logic [31:0] ref_y(input int n, input logic [31:0] a, input int b,
                                        input logic lf, input logic rt, input logic at);
    logic [31:0] y = '0;
    for (int i = 0; i < n; i++) begin
      int src;
      if (rt) begin
        src = lf ? (i - b + n) % n : (i + b) % n;
        y[i] = a[src];
      end else if (!lf) begin
        src = i + b;
        y[i] = (src < n) ? a[src] : (at ? a[n-1] : 1'b0);
      end else begin
        src = i - b;
        y[i] = (src >= 0) ? a[src] : 1'b0;
      end
    end
    if (lf && !rt && at) y[n-1] = a[n-1];
    return y;
  endfunction

  function automatic logic ref_ovf(input int n, input logic [31:0] a, input int b,
                                   input logic lf, input logic rt, input logic at);
    logic o = 1'b0;
    if (lf && !rt && at)
      for (int j = n - 1 - b; j <= n - 2; j++)
        if (a[j] != a[n-1]) o = 1'b1;
    return o;
  endfunction

  function automatic string op_tag(input logic lf, input logic rt, input logic at, input int b);
    if (b == 0) return "R9";
    if (rt) return at ? "R1 R4" : "R4";
    if (!lf) return at ? "R3" : "R2";
    return at ? "R6" : "R5";
  endfunction

  task automatic apply(input logic [31:0] na32, input int nb32, input logic [7:0] na8,
                       input int nb8, input logic nl, input logic nr, input logic nar);
    item_t it;
    @(posedge clk);
    #1;
    a32 = na32; b32 = 5'(nb32); a8 = na8; b8 = 3'(nb8);
    l = nl; r = nr; ar = nar;
    it.y32 = ref_y(32, na32, nb32, nl, nr, nar);
    it.z32 = (it.y32 == 32'd0);
    it.o32 = ref_ovf(32, na32, nb32, nl, nr, nar);
    it.y8  = ref_y(8, {24'd0, na8}, nb8, nl, nr, nar);
    it.z8  = (it.y8[7:0] == 8'd0);
    it.o8  = ref_ovf(8, {24'd0, na8}, nb8, nl, nr, nar);
    it.tag = op_tag(nl, nr, nar, nb32);
    q.push_back(it);
  endtask

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.tag, y32, it.y32);
      cmp("R8 w32", {31'd0, z32}, {31'd0, it.z32});
      cmp("R7 w32", {31'd0, o32}, {31'd0, it.o32});
      cmp(it.tag, {24'd0, y8}, {24'd0, it.y8[7:0]});
      cmp("R8 w8", {31'd0, z8}, {31'd0, it.z8});
      cmp("R7 w8", {31'd0, o8}, {31'd0, it.o8});
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle inputs: all zero in, zero result, zero flag set, no overflow (R8, R9).
    @(negedge clk);
    cmp("R9 idle y", y32, 32'd0);
    cmp("R8 idle zero", {31'd0, z32}, 32'd1);
    cmp("R7 idle ovf", {31'd0, o32}, 32'd0);
    // Directed: overflow and zero together (R7, R8).
    apply(32'h4000_0000, 2, 8'h40, 2, 1'b1, 1'b0, 1'b1);
    apply(32'h8000_0000, 5, 8'h80, 5, 1'b1, 1'b0, 1'b1);
    apply(32'h7FFF_FFFF, 31, 8'h7F, 7, 1'b1, 1'b0, 1'b1);
    apply(32'h8000_0001, 31, 8'h81, 7, 1'b0, 1'b0, 1'b1);
    apply(32'hFFFF_FFFF, 0, 8'hFF, 0, 1'b1, 1'b0, 1'b1);
    // Sweep every control code, amount, several operands.
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 32; b++)
        for (int k = 0; k < 4; k++) begin
          logic [31:0] v;
          v = $urandom();
          if (k == 0) v = 32'd0;
          apply(v, b, v[7:0] ^ v[31:24], b % 8, c[2], c[1], c[0]);
        end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule